// File: doc/BRIEF.md
# Status-decoded bus command generator

This block sits beside a processor core that announces each bus cycle only through a 3-bit status code. It watches that code, detects when a new cycle begins, and walks a phase counter through T1, T2, T3, optional wait states and T4. From the phase and the captured code it drives these outputs:

- an address latch pulse
- a data enable
- a data direction level
- active-low read, write and interrupt-acknowledge commands for the memory and I/O spaces
- early variants of the two write commands

A cycle is recognised only when the status moves from the passive code 111 to any other code except halt (011). The code is sampled and captured on the clock edge that starts T1. A core that returns the status to passive during T3 can put the next code out during T4, so cycles run back to back with no idle clock between them.

Top module: `bus_cmd_gen`

## Requirements
- R1: The captured code selects the command: 000 interrupt acknowledge (`inta_n`), 001 I/O read (`iord_n`), 010 I/O write (`iowr_n`/`aiowr_n`), 100 code fetch and 101 memory read (both `mrd_n`), 110 memory write (`mwr_n`/`amwr_n`). 111 is passive and 011 is halt.
- R2: A cycle starts only on a clock edge where the previously sampled status was 111 and the present status is a non-halt, non-passive code, while the block is idle or in T4. T1 follows that edge. A code held without passing through 111 never starts a second cycle.
- R3: `ale` is high for exactly the one clock of T1 and low at all other times.
- R4: Read and interrupt-acknowledge commands are low in T2, T3 and every wait state, and high again in T4.
- R5: `mwr_n`/`iowr_n` are low in T3 and wait states. `amwr_n`/`aiowr_n` go low one clock earlier, in T2, and rise together with the normal command at T4.
- R6: `den` is high from T2 through T4 of every cycle and low in idle and T1.
- R7: `dt_tx` is high from T1 through T4 of write cycles (010, 110). It is low for all other codes and when idle.
- R8: If `rdy` is low on the edge that ends T3, wait states are inserted. They continue, with every active command and `den` held, until `rdy` is high on the edge that ends a wait state, after which T4 follows.
- R9: The halt code starts no cycle: no `ale`, no `den` and no command strobe.
- R10: Two consecutive interrupt-acknowledge cycles produce two separate `inta_n` low pulses.
- R11: While `rst` is high, all outputs are inactive (strobes and levels low, commands high), and the captured status is passive.
- R12: At most one of the five normal command outputs is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stat | input | 3 | Status code from the core |
| rdy | input | 1 | Transfer ready, sampled at the end of T3 and of each wait state |
| ale | output | 1 | Address latch pulse in T1 |
| den | output | 1 | Data enable, T2 to T4 |
| dt_tx | output | 1 | High when the core transmits |
| mrd_n | output | 1 | Memory read command |
| mwr_n | output | 1 | Memory write command |
| iord_n | output | 1 | I/O read command |
| iowr_n | output | 1 | I/O write command |
| inta_n | output | 1 | Interrupt acknowledge command |
| amwr_n | output | 1 | Early memory write command |
| aiowr_n | output | 1 | Early I/O write command |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. It sweeps every command-producing status code against zero to three wait states and compares all ten outputs in every phase against a vector computed from the code and phase. Back-to-back cycles, a held code that must not restart, a halt code, paired acknowledge cycles and a reset in mid-cycle cover the boundary cases.

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_stat,
  input  logic       rdy,
  output logic       ale,
  output logic       den,
  output logic       dt_tx,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       inta_n,
  output logic       amwr_n,
  output logic       aiowr_n
);

  localparam logic [2:0] ST_IACK = 3'b000;
  localparam logic [2:0] ST_IORD = 3'b001;
  localparam logic [2:0] ST_IOWR = 3'b010;
  localparam logic [2:0] ST_HALT = 3'b011;
  localparam logic [2:0] ST_CODE = 3'b100;
  localparam logic [2:0] ST_MRD  = 3'b101;
  localparam logic [2:0] ST_MWR  = 3'b110;
  localparam logic [2:0] ST_IDLE = 3'b111;

  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4} phase_t;

  phase_t     ph;
  logic [2:0] stat_q;
  logic [2:0] code;
  logic       start;

  assign start = (stat_q == ST_IDLE) && (bus_stat != ST_IDLE) && (bus_stat != ST_HALT)
              && (ph == PH_IDLE || ph == PH_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      stat_q <= ST_IDLE;
      code   <= ST_IDLE;
    end else begin
      stat_q <= bus_stat;
      if (start) code <= bus_stat;
      case (ph)
        PH_IDLE: if (start) ph <= PH_T1;
        PH_T1:   ph <= PH_T2;
        PH_T2:   ph <= PH_T3;
        PH_T3:   ph <= rdy ? PH_T4 : PH_TW;
        PH_TW:   ph <= rdy ? PH_T4 : PH_TW;
        PH_T4:   ph <= start ? PH_T1 : PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic cmd_win, wr_win, is_wr;
  assign cmd_win = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
  assign wr_win  = (ph == PH_T3) || (ph == PH_TW);
  assign is_wr   = (code == ST_IOWR) || (code == ST_MWR);

  assign ale     = (ph == PH_T1);
  assign den     = cmd_win || (ph == PH_T4);
  assign dt_tx   = is_wr && (ph != PH_IDLE);
  assign mrd_n   = !(((code == ST_CODE) || (code == ST_MRD)) && cmd_win);
  assign iord_n  = !((code == ST_IORD) && cmd_win);
  assign inta_n  = !((code == ST_IACK) && cmd_win);
  assign mwr_n   = !((code == ST_MWR) && wr_win);
  assign iowr_n  = !((code == ST_IOWR) && wr_win);
  assign amwr_n  = !((code == ST_MWR) && cmd_win);
  assign aiowr_n = !((code == ST_IOWR) && cmd_win);

  logic [4:0] cmd_low;
  assign cmd_low = ~{mrd_n, mwr_n, iord_n, iowr_n, inta_n};

  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  a_r5_early_write_leads: assert property (@(posedge clk) disable iff (rst)
    $fell(mwr_n) |-> !$past(amwr_n));
  a_r5_early_io_leads: assert property (@(posedge clk) disable iff (rst)
    $fell(iowr_n) |-> !$past(aiowr_n));
  a_r12_one_cmd: assert property (@(posedge clk) disable iff (rst) $onehot0(cmd_low));
  a_r6_den_with_cmd: assert property (@(posedge clk) disable iff (rst) (|cmd_low) |-> den);
  a_r7_read_receives: assert property (@(posedge clk) disable iff (rst)
    (!mrd_n || !iord_n || !inta_n) |-> !dt_tx);
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_win && !rdy && (|cmd_low)) |=> $stable(cmd_low));

endmodule

// File: tb/bus_cmd_gen_tb.sv
`timescale 1ns/1ps
module bus_cmd_gen_tb_top;
  logic clk = 0, rst = 1, rdy = 1;
  logic [2:0] bus_stat = 3'b111;
  logic ale, den, dt_tx, mrd_n, mwr_n, iord_n, iowr_n, inta_n, amwr_n, aiowr_n;
  int total = 0, fails = 0, falls = 0;
  logic prev_inta = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_cmd_gen dut_i (.clk(clk), .rst(rst), .bus_stat(bus_stat), .rdy(rdy), .ale(ale), .den(den),
    .dt_tx(dt_tx), .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .inta_n(inta_n), .amwr_n(amwr_n), .aiowr_n(aiowr_n));

  always @(negedge clk) begin
    if (prev_inta && !inta_n) falls++;
    prev_inta = inta_n;
  end

  // phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait
  function automatic logic [9:0] expv(input logic [2:0] c, input int ph);
    logic cw, ww, rd;
    cw = (ph == 2 || ph == 3 || ph == 5);
    ww = (ph == 3 || ph == 5);
    rd = (c == 3'b100 || c == 3'b101);
    return {ph == 1, ph >= 2, (c == 3'b010 || c == 3'b110) && ph != 0,
            !(rd && cw), !(c == 3'b110 && ww), !(c == 3'b001 && cw),
            !(c == 3'b010 && ww), !(c == 3'b000 && cw),
            !(c == 3'b110 && cw), !(c == 3'b010 && cw)};
  endfunction

  task automatic chk(input logic [2:0] c, input int ph, input string tag);
    logic [9:0] act, exp_v;
    act = {ale, den, dt_tx, mrd_n, mwr_n, iord_n, iowr_n, inta_n, amwr_n, aiowr_n};
    exp_v = expv(c, ph);
    total++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s code=%b phase=%0d actual=%b expected=%b", tag, c, ph, act, exp_v);
    end
  endtask

  task automatic idle_chk(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(3'b111, 0, tag);
    end
  endtask

  // Drives one bus cycle starting at a negedge where the block is idle or in T4.
  task automatic run_cyc(input logic [2:0] c, input int waits, input bit hold);
    string tag;
    tag = (c == 3'b010 || c == 3'b110) ? "R5 R6 R7" : "R1 R4 R6 R7";
    bus_stat = c;
    @(negedge clk); chk(c, 1, "R3 T1");
    @(negedge clk); chk(c, 2, tag);
    if (!hold) bus_stat = 3'b111;
    @(negedge clk); chk(c, 3, tag);
    rdy = (waits == 0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk); chk(c, 5, "R8 wait");
      rdy = (w == waits - 1);
    end
    @(negedge clk); chk(c, 4, tag);
    rdy = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(3'b111, 0, "R11 reset");
    rst = 0;
    idle_chk(2, "R2 idle");
    // R1 R4 R5 R6 R7 R8 R12: every command code against 0..3 wait states
    for (int k = 0; k < 6; k++) begin
      logic [2:0] c;
      c = (k < 3) ? 3'(k) : 3'(k + 1);
      for (int w = 0; w < 4; w++) begin
        run_cyc(c, w, 0);
        idle_chk(1, "R2 end");
      end
    end
    // R2: back-to-back cycles, next code issued during T4
    run_cyc(3'b101, 0, 0);
    run_cyc(3'b110, 1, 0);
    run_cyc(3'b001, 0, 0);
    idle_chk(1, "R2 back-to-back end");
    // R10: two acknowledge cycles give two pulses
    falls = 0;
    run_cyc(3'b000, 0, 0);
    run_cyc(3'b000, 2, 0);
    idle_chk(1, "R10 end");
    total++;
    if (falls != 2) begin
      fails++;
      $display("FAIL R10 inta pulses actual=%0d expected=2", falls);
    end
    // R2: code held with no passive return must not restart
    run_cyc(3'b101, 0, 1);
    idle_chk(3, "R2 held code");
    bus_stat = 3'b111;
    idle_chk(1, "R2 held code");
    // R9: halt starts nothing
    bus_stat = 3'b011;
    idle_chk(5, "R9 halt");
    bus_stat = 3'b111;
    idle_chk(1, "R9 halt");
    run_cyc(3'b100, 0, 0);
    idle_chk(1, "R9 after halt");
    // R11: reset in mid-cycle
    bus_stat = 3'b101;
    @(negedge clk); @(negedge clk);
    rst = 1; bus_stat = 3'b111;
    @(negedge clk); chk(3'b111, 0, "R11 mid-cycle reset");
    rst = 0;
    idle_chk(1, "R11 after reset");
    run_cyc(3'b001, 0, 0);
    idle_chk(1, "R11 recovery");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule